// File: doc/BRIEF.md
# Count and String Pointer Sequencer

This block keeps the iteration count and the two string pointers that a 16-bit processor uses for counted loops and repeated string moves. Each clock it accepts at most one command: a decrement-and-branch loop step, a test that branches when the count is zero, or one element of a repeated string move. It reports whether a branch is taken and whether a string element was performed, and it presents the updated register values. A separate load port writes the count, both pointers and a held condition word. It takes priority over any command in the same cycle.

The loop step decrements before it tests, so a count of zero wraps and produces 65,536 passes. A string element moves both pointers by the element size (1 byte or 2 bytes), upwards or downwards as the direction input selects. No command alters the condition word. Instruction decode, memory traffic and the data moved lie outside the block.

Top module: `count_string_seq`

## Requirements
- R1: After a synchronous reset the count, source pointer, destination pointer and condition word read 0, and branch_taken and iter_active are 0.
- R2: A loop step (cmd_op = 2'b01) sets the count to count-1 one cycle later, and branch_taken is 1 in that cycle only when the new count is nonzero.
- R3: A loop step with count 0 wraps the count to 16'hFFFF with branch_taken 1, so a loop entered at 0 runs 65,536 passes before the branch is not taken.
- R4: A zero test (cmd_op = 2'b10) sets branch_taken to 1 when the count is 0, and it leaves the count and both pointers unchanged.
- R5: No command (cmd_op 2'b01, 2'b10 or 2'b11) changes the condition word. Only the load port writes it.
- R6: A string step (cmd_op = 2'b11) with a nonzero count decrements the count by one and sets iter_active to 1. branch_taken is 1 when the new count is nonzero, meaning the repetition continues.
- R7: On each string element, both pointers move by 1 when cmd_wide is 0 and by 2 when cmd_wide is 1.
- R8: With dir at 0 the pointers increase, and with dir at 1 they decrease. All count and pointer arithmetic wraps modulo 2^16.
- R9: A string step issued with the count at 0 performs no element: iter_active and branch_taken are 0, and the count and both pointers are unchanged.
- R10: When ld_en is 1, the count, both pointers and the condition word take the load values. Any command in the same cycle is dropped, so branch_taken and iter_active are 0.
- R11: When cmd_op is 2'b00 and ld_en is 0, all registers hold, and branch_taken and iter_active are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Command: 00 none, 01 loop step, 10 zero test, 11 string step |
| cmd_wide | input | 1 | Element size for string steps: 0 byte, 1 word |
| dir | input | 1 | Direction: 0 increment, 1 decrement |
| ld_en | input | 1 | Load strobe, has priority over commands |
| ld_cnt | input | 16 | Count load value |
| ld_src | input | 16 | Source pointer load value |
| ld_dst | input | 16 | Destination pointer load value |
| ld_cond | input | 16 | Condition word load value |
| cnt | output | 16 | Current count |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| cond_word | output | 16 | Held condition word |
| branch_taken | output | 1 | Registered branch or repeat-continue decision of the last command |
| iter_active | output | 1 | Registered: a string element was performed in the last cycle |

## Verification
A load and a command can arrive in the same cycle. The bench drives ld_en together with each kind of command, including a string step that would otherwise decrement the count and move the pointers. The load must win: the registers must hold exactly the load values, and both result outputs must be 0. A behavioural reference model is compared against every output on each clock, so a merged or half-applied update shows up in that cycle.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_LOOP   = 2'b01,
        OP_TESTZ  = 2'b10,
        OP_STRING = 2'b11
    } seq_op_e;

    typedef struct packed {
        logic taken;
        logic active;
    } seq_result_t;

    function automatic int unsigned elem_stride(input logic wide);
        return wide ? 2 : 1;
    endfunction

endpackage

// File: rtl/cseq_count.sv
module cseq_count
    import cseq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  seq_op_e      op,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         elem_fire,
    output seq_result_t  result
);

    logic [W-1:0] cnt_q, cnt_d, cnt_dec;
    seq_result_t  res_q, res_d;

    assign cnt_dec = cnt_q - W'(1);

    always_comb begin
        cnt_d     = cnt_q;
        res_d     = '0;
        elem_fire = 1'b0;
        if (ld_en) begin
            cnt_d = ld_val;
        end else begin
            case (op)
                OP_LOOP: begin
                    cnt_d       = cnt_dec;
                    res_d.taken = (cnt_dec != '0);
                end
                OP_TESTZ: begin
                    res_d.taken = (cnt_q == '0);
                end
                OP_STRING: begin
                    if (cnt_q != '0) begin
                        elem_fire    = 1'b1;
                        cnt_d        = cnt_dec;
                        res_d.active = 1'b1;
                        res_d.taken  = (cnt_dec != '0);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            res_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            res_q <= res_d;
        end
    end

    assign cnt    = cnt_q;
    assign result = res_q;

    // R2 / R3: loop step decrements (with wrap) and branches on nonzero
    a_r2_loop_dec: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOOP && !ld_en) |=> (cnt_q == $past(cnt_q) - W'(1)) &&
                                      (res_q.taken == ($past(cnt_q) != W'(1))));

    // R4: zero test leaves the count alone
    a_r4_test_hold: assert property (@(posedge clk) disable iff (rst)
        (op == OP_TESTZ && !ld_en) |=> $stable(cnt_q) &&
                                       (res_q.taken == ($past(cnt_q) == '0)));

    // R10: load wins over any command
    a_r10_load_cnt: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (cnt_q == $past(ld_val)) && !res_q.taken && !res_q.active);

    // R11: idle holds
    a_r11_idle: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NONE && !ld_en) |=> $stable(cnt_q) && !res_q.taken && !res_q.active);

endmodule

// File: rtl/cseq_index.sv
module cseq_index
    import cseq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    input  logic         step_en,
    input  logic         wide,
    input  logic         dir,
    output logic [W-1:0] ptr
);

    logic [W-1:0] ptr_q, stride;

    assign stride = W'(elem_stride(wide));

    always_ff @(posedge clk) begin
        if (rst)          ptr_q <= '0;
        else if (ld_en)   ptr_q <= ld_val;
        else if (step_en) ptr_q <= dir ? (ptr_q - stride) : (ptr_q + stride);
    end

    assign ptr = ptr_q;

    // R7 / R8: pointer moves by element size in the chosen direction
    a_r7_stride: assert property (@(posedge clk) disable iff (rst)
        (step_en && !ld_en) |=>
            (($past(dir) ? ($past(ptr_q) - ptr_q) : (ptr_q - $past(ptr_q)))
             == ($past(wide) ? W'(2) : W'(1))));

    // R10: load value taken
    a_r10_load_ptr: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> ptr_q == $past(ld_val));

    // R9 / R4: no element means no movement
    a_r9_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !ld_en) |=> $stable(ptr_q));

endmodule

// File: rtl/cseq_cond_hold.sv
module cseq_cond_hold #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] cond
);

    logic [CW-1:0] cond_q;

    always_ff @(posedge clk) begin
        if (rst)        cond_q <= '0;
        else if (ld_en) cond_q <= ld_val;
    end

    assign cond = cond_q;

    // R5: commands never touch the condition word
    a_r5_cond_hold: assert property (@(posedge clk) disable iff (rst)
        !ld_en |=> $stable(cond_q));

endmodule

// File: rtl/count_string_seq.sv
module count_string_seq
    import cseq_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cmd_op,
    input  logic          cmd_wide,
    input  logic          dir,
    input  logic          ld_en,
    input  logic [W-1:0]  ld_cnt,
    input  logic [W-1:0]  ld_src,
    input  logic [W-1:0]  ld_dst,
    input  logic [CW-1:0] ld_cond,
    output logic [W-1:0]  cnt,
    output logic [W-1:0]  src_ptr,
    output logic [W-1:0]  dst_ptr,
    output logic [CW-1:0] cond_word,
    output logic          branch_taken,
    output logic          iter_active
);

    localparam int NIDX = 2;

    seq_op_e      op;
    logic         elem_fire;
    seq_result_t  result;
    logic [W-1:0] idx_ld  [NIDX];
    logic [W-1:0] idx_ptr [NIDX];

    assign op        = seq_op_e'(cmd_op);
    assign idx_ld[0] = ld_src;
    assign idx_ld[1] = ld_dst;

    cseq_count #(.W(W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .ld_en     (ld_en),
        .ld_val    (ld_cnt),
        .cnt       (cnt),
        .elem_fire (elem_fire),
        .result    (result)
    );

    for (genvar g = 0; g < NIDX; g++) begin : g_idx
        cseq_index #(.W(W)) u_index (
            .clk     (clk),
            .rst     (rst),
            .ld_en   (ld_en),
            .ld_val  (idx_ld[g]),
            .step_en (elem_fire),
            .wide    (cmd_wide),
            .dir     (dir),
            .ptr     (idx_ptr[g])
        );
    end

    cseq_cond_hold #(.CW(CW)) u_cond (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .ld_val (ld_cond),
        .cond   (cond_word)
    );

    assign src_ptr      = idx_ptr[0];
    assign dst_ptr      = idx_ptr[1];
    assign branch_taken = result.taken;
    assign iter_active  = result.active;

    // R9: string step at zero count does nothing
    a_r9_zero_noop: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STRING && cnt == '0 && !ld_en) |=>
            !iter_active && !branch_taken && $stable(cnt) &&
            $stable(src_ptr) && $stable(dst_ptr));

    // R6: string element decrements count and flags activity
    a_r6_elem: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STRING && cnt != '0 && !ld_en) |=>
            iter_active && (cnt == $past(cnt) - W'(1)) &&
            (branch_taken == (cnt != '0)));

    // R1: outputs quiet right after reset
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (cnt == '0) && (src_ptr == '0) && (dst_ptr == '0) &&
                (cond_word == '0) && !branch_taken && !iter_active);

endmodule

// File: tb/tb_count_string_seq.sv
`timescale 1ns/1ps
module tb_count_string_seq;

    localparam int W  = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cmd_op = 2'b00;
    logic          cmd_wide = 1'b0;
    logic          dir = 1'b0;
    logic          ld_en = 1'b0;
    logic [W-1:0]  ld_cnt = '0, ld_src = '0, ld_dst = '0;
    logic [CW-1:0] ld_cond = '0;
    logic [W-1:0]  cnt, src_ptr, dst_ptr;
    logic [CW-1:0] cond_word;
    logic          branch_taken, iter_active;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_cnt = '0, m_src = '0, m_dst = '0, m_cond = '0;
    logic        m_tk = 1'b0, m_ac = 1'b0;

    always #4 clk = ~clk;

    count_string_seq #(.W(W), .CW(CW)) dut (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_wide(cmd_wide), .dir(dir),
        .ld_en(ld_en), .ld_cnt(ld_cnt), .ld_src(ld_src), .ld_dst(ld_dst),
        .ld_cond(ld_cond), .cnt(cnt), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
        .cond_word(cond_word), .branch_taken(branch_taken), .iter_active(iter_active)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp,
                       input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(cnt, m_cnt, tag, "cnt");
        chk(src_ptr, m_src, tag, "src_ptr");
        chk(dst_ptr, m_dst, tag, "dst_ptr");
        chk(cond_word, m_cond, tag, "cond_word");
        chk({15'd0, branch_taken}, {15'd0, m_tk}, tag, "branch_taken");
        chk({15'd0, iter_active}, {15'd0, m_ac}, tag, "iter_active");
    endtask

    task automatic model_step();
        int stride;
        stride = cmd_wide ? 2 : 1;
        m_tk = 1'b0;
        m_ac = 1'b0;
        if (rst) begin
            m_cnt = '0; m_src = '0; m_dst = '0; m_cond = '0;
        end else if (ld_en) begin
            m_cnt = ld_cnt; m_src = ld_src; m_dst = ld_dst; m_cond = ld_cond;
        end else begin
            case (cmd_op)
                2'b01: begin
                    m_cnt = m_cnt - 16'd1;
                    m_tk  = (m_cnt != 0);
                end
                2'b10: m_tk = (m_cnt == 0);
                2'b11: if (m_cnt != 0) begin
                    m_cnt = m_cnt - 16'd1;
                    m_ac  = 1'b1;
                    m_tk  = (m_cnt != 0);
                    if (dir) begin
                        m_src = m_src - 16'(stride);
                        m_dst = m_dst - 16'(stride);
                    end else begin
                        m_src = m_src + 16'(stride);
                        m_dst = m_dst + 16'(stride);
                    end
                end
                default: ;
            endcase
        end
    endtask

    // drive at negedge, advance, compare at next negedge
    task automatic cyc(input logic [1:0] op, input logic wide, input logic d, input string tag);
        cmd_op = op; cmd_wide = wide; dir = d; ld_en = 1'b0;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic load(input logic [15:0] c, input logic [15:0] s, input logic [15:0] dd,
                        input logic [15:0] cw, input logic [1:0] op, input string tag);
        ld_en = 1'b1; ld_cnt = c; ld_src = s; ld_dst = dd; ld_cond = cw; cmd_op = op;
        cmd_wide = 1'b1; dir = 1'b0;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all(tag);
        ld_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int passes;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare_all("R1");

        // R10 load, R11 idle
        load(16'd3, 16'h1000, 16'h2000, 16'hA5C3, 2'b00, "R10");
        cyc(2'b00, 1'b0, 1'b0, "R11");

        // R2 loop steps down to zero, R5 cond held
        cyc(2'b01, 1'b0, 1'b0, "R2");
        cyc(2'b01, 1'b0, 1'b0, "R2");
        cyc(2'b01, 1'b0, 1'b0, "R2");
        chk(cond_word, 16'hA5C3, "R5", "cond after loops");

        // R4 zero test at zero and nonzero
        cyc(2'b10, 1'b0, 1'b0, "R4");
        load(16'd7, 16'h0010, 16'h0020, 16'hA5C3, 2'b00, "R10");
        cyc(2'b10, 1'b0, 1'b0, "R4");

        // R3 wrap from zero: count passes
        load(16'd0, 16'h0, 16'h0, 16'h0F0F, 2'b00, "R10");
        passes = 0;
        for (int i = 0; i < 70000; i++) begin
            cyc(2'b01, 1'b0, 1'b0, "R3");
            passes++;
            if (!branch_taken) break;
        end
        chk(16'(passes), 16'd0, "R3", "passes mod 2^16");
        chk({15'd0, passes == 65536}, 16'd1, "R3", "pass count 65536");
        chk(cond_word, 16'h0F0F, "R5", "cond after wrap");

        // R6/R7/R8 byte increment
        load(16'd3, 16'h0100, 16'h0200, 16'h1234, 2'b00, "R10");
        for (int i = 0; i < 3; i++) cyc(2'b11, 1'b0, 1'b0, "R6_R7_R8");
        // R9 at zero count
        cyc(2'b11, 1'b0, 1'b0, "R9");
        cyc(2'b11, 1'b1, 1'b1, "R9");

        // word decrement wrapping below zero
        load(16'd3, 16'h0002, 16'h0001, 16'h1234, 2'b00, "R10");
        for (int i = 0; i < 3; i++) cyc(2'b11, 1'b1, 1'b1, "R7_R8");
        chk(src_ptr, 16'hFFFC, "R8", "src wrap down");
        chk(dst_ptr, 16'hFFFB, "R8", "dst wrap down");

        // word increment wrapping above FFFF
        load(16'd2, 16'hFFFE, 16'hFFFF, 16'h1234, 2'b00, "R10");
        cyc(2'b11, 1'b1, 1'b0, "R7_R8");
        cyc(2'b11, 1'b1, 1'b0, "R7_R8");
        chk(src_ptr, 16'h0002, "R8", "src wrap up");

        // R10 load collides with each command
        load(16'd5, 16'h4000, 16'h5000, 16'h00FF, 2'b11, "R10");
        load(16'd0, 16'h4100, 16'h5100, 16'h00FE, 2'b01, "R10");
        load(16'd0, 16'h4200, 16'h5200, 16'h00FD, 2'b10, "R10");
        cyc(2'b10, 1'b0, 1'b0, "R4");
        cyc(2'b00, 1'b0, 1'b0, "R11");

        // R1 reset mid-run
        rst = 1'b1;
        cyc(2'b11, 1'b0, 1'b0, "R1");
        rst = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule